// File: doc/BRIEF.md
# Pattern Generator Sequencing Controller

This block is the control state machine that sits in front of a multi-channel sine synthesizer. It takes already-debounced start, stop and trigger levels and drives the four control lines of the synthesizer datapath: clock enable, synchronous clear, register write enable and register select. It also reports its current state as a fixed 3-bit code.

A run begins with a start pulse. The machine then spends one clock writing the phase increment and one clock writing the phase offset. It then waits for the first trigger. Each rising edge of the trigger places the machine in a one-clock phase-reset state, which clears the synthesizer's phase accumulators back to their configured offset. After that the synthesizer free-runs until the next trigger. A stop request from any active state ends the current run and parks the machine in idle, where the synthesizer is held cleared.

The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block.

Top module: `pgen_ctrl`

## Requirements
- R1: While reset is applied and after its synchronized release, the machine is idle. Idle reports code 000 with clock enable 0, synchronous clear 1, write enable 0 and register select 0.
- R2: A high start input in idle moves the machine to the increment-config state on the next clock. Start has no effect in any other state.
- R3: The increment-config state reports code 001 and drives write enable 1, register select 0, clock enable 0 and clear 0. It lasts exactly one clock and then goes to offset-config.
- R4: The offset-config state reports code 010 and drives write enable 1, register select 1, clock enable 0 and clear 0. It lasts exactly one clock and then goes to wait-for-trigger.
- R5: The wait-for-trigger state reports code 011 with all four control outputs at 0. It stays there until a trigger rising edge arrives.
- R6: A trigger rising edge in wait-for-trigger or in run moves the machine to phase-reset. Phase-reset reports code 101, drives clock enable 1, clear 1 and write enable 0, and lasts one clock before going to run.
- R7: The run state reports code 100 with clock enable 1 and clear, write enable and register select all 0. It stays in run until a trigger edge or a stop.
- R8: A trigger rising edge is a clock where trigger is high and was low on the clock before. A trigger held high for many clocks produces only one phase-reset. Trigger must return low before it can cause another one.
- R9: A high stop input in any non-idle state returns the machine to idle on the next clock. Stop takes priority over a simultaneous trigger edge.
- R10: In idle, stop and trigger have no effect. The machine stays at code 000 with the idle outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Debounced start request (level) |
| stop_i | input | 1 | Debounced stop request (level) |
| trig_i | input | 1 | Debounced trigger (rising edge acts) |
| syn_ce_o | output | 1 | Synthesizer clock enable |
| syn_sclr_o | output | 1 | Synthesizer synchronous clear |
| syn_we_o | output | 1 | Synthesizer configuration write enable |
| syn_sel_o | output | 1 | Register select: 0 increment, 1 offset |
| state_code_o | output | 3 | Current state code |

## Verification
The assertions watch every clock for a set of sequencing rules:
- start leads into increment-config;
- the two configuration states advance in order after one clock;
- phase-reset hands over to run;
- stop always lands in idle;
- the edge detector never fires on two clocks in a row;
- write enable never coincides with clock enable or clear.

The bench scenarios are needed for the rest. They show the full output code of each state, and that a long trigger pulse yields a single phase-reset. They also show that start, stop and trigger leave idle and the other states untouched where they must, and that stop beats a trigger arriving in the same clock.

// File: rtl/pgen_ctrl_pkg.sv
package pgen_ctrl_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_INC  = 3'b001,
    ST_OFF  = 3'b010,
    ST_WAIT = 3'b011,
    ST_RUN  = 3'b100,
    ST_PRST = 3'b101
  } pg_state_e;

  typedef struct packed {
    logic ce;
    logic sclr;
    logic we;
    logic sel;
  } pg_ctl_t;

endpackage

// File: rtl/pgen_rst_sync.sv
module pgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/pgen_edge_det.sv
module pgen_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R8: a rising edge can never be reported on two consecutive clocks
  assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pgen_seq_fsm.sv
module pgen_seq_fsm
  import pgen_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      trig_rise_i,
  output pg_state_e state_o
);

  pg_state_e state_q;
  pg_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_INC;
      ST_INC:  state_d = stop_i ? ST_IDLE : ST_OFF;
      ST_OFF:  state_d = stop_i ? ST_IDLE : ST_WAIT;
      ST_WAIT: begin
        if (stop_i)           state_d = ST_IDLE;
        else if (trig_rise_i) state_d = ST_PRST;
      end
      ST_PRST: state_d = stop_i ? ST_IDLE : ST_RUN;
      ST_RUN: begin
        if (stop_i)           state_d = ST_IDLE;
        else if (trig_rise_i) state_d = ST_PRST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: start in idle enters increment-config
  assert_start_enters_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> state_q == ST_INC);

  // R3: increment-config lasts one clock
  assert_inc_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INC && !stop_i) |=> state_q == ST_OFF);

  // R4: offset-config lasts one clock
  assert_off_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !stop_i) |=> state_q == ST_WAIT);

  // R6: phase-reset hands over to run
  assert_prst_to_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRST && !stop_i) |=> state_q == ST_RUN);

  // R9: stop from an active state lands in idle
  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && stop_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/pgen_out_decode.sv
module pgen_out_decode
  import pgen_ctrl_pkg::*;
(
  input  pg_state_e state_i,
  output pg_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '{ce: 1'b0, sclr: 1'b0, we: 1'b0, sel: 1'b0};
    unique case (state_i)
      ST_IDLE: ctl_o.sclr = 1'b1;
      ST_INC:  ctl_o.we   = 1'b1;
      ST_OFF: begin
        ctl_o.we  = 1'b1;
        ctl_o.sel = 1'b1;
      end
      ST_WAIT: ctl_o = '{ce: 1'b0, sclr: 1'b0, we: 1'b0, sel: 1'b0};
      ST_PRST: begin
        ctl_o.ce   = 1'b1;
        ctl_o.sclr = 1'b1;
      end
      ST_RUN:  ctl_o.ce = 1'b1;
      default: ctl_o.sclr = 1'b1;
    endcase
  end

endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_ctrl_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               trig_i,
  output logic               syn_ce_o,
  output logic               syn_sclr_o,
  output logic               syn_we_o,
  output logic               syn_sel_o,
  output logic [STATE_W-1:0] state_code_o
);

  logic      rst_int_n;
  logic      trig_rise;
  pg_state_e state;
  pg_ctl_t   ctl;

  pgen_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pgen_edge_det u_trig_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (trig_i),
    .rise_o  (trig_rise)
  );

  pgen_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .trig_rise_i (trig_rise),
    .state_o     (state)
  );

  pgen_out_decode u_dec (
    .state_i (state),
    .ctl_o   (ctl)
  );

  assign syn_ce_o     = ctl.ce;
  assign syn_sclr_o   = ctl.sclr;
  assign syn_we_o     = ctl.we;
  assign syn_sel_o    = ctl.sel;
  assign state_code_o = state;

  // R3/R4: configuration writes never overlap running or clearing
  assert_we_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    syn_we_o |-> (!syn_ce_o && !syn_sclr_o));

  // R6: clear while enabled only in phase-reset, which follows a trigger edge
  assert_prst_after_edge_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trig_rise && !stop_i && (state == ST_RUN || state == ST_WAIT))
      |=> (syn_ce_o && syn_sclr_o));

endmodule

// File: tb/tb_pgen_ctrl.sv
module tb_pgen_ctrl;

  logic       clk;
  logic       rst_n;
  logic       start_i, stop_i, trig_i;
  logic       syn_ce_o, syn_sclr_o, syn_we_o, syn_sel_o;
  logic [2:0] state_code_o;

  int n_chk  = 0;
  int n_fail = 0;

  pgen_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .trig_i       (trig_i),
    .syn_ce_o     (syn_ce_o),
    .syn_sclr_o   (syn_sclr_o),
    .syn_we_o     (syn_we_o),
    .syn_sel_o    (syn_sel_o),
    .state_code_o (state_code_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {code, ce, sclr, we, sel}
  localparam logic [6:0] E_IDLE = {3'b000, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [6:0] E_INC  = {3'b001, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [6:0] E_OFF  = {3'b010, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [6:0] E_WAIT = {3'b011, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [6:0] E_RUN  = {3'b100, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [6:0] E_PRST = {3'b101, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {state_code_o, syn_ce_o, syn_sclr_o, syn_we_o, syn_sel_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic go_to_wait();
    start_i = 1'b1; step(); start_i = 1'b0;
    step(); step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; trig_i = 1'b0;
    repeat (3) step();
    expect_out("R1 in reset", E_IDLE);
    rst_n = 1'b1;
    repeat (3) step();
    expect_out("R1 after release", E_IDLE);
  endtask

  task automatic t_idle_ignore();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    expect_out("R10 stop in idle", E_IDLE);
    trig_i = 1'b1; step(); trig_i = 1'b0;
    expect_out("R10 trigger in idle", E_IDLE);
    step();
    expect_out("R10 idle holds", E_IDLE);
  endtask

  task automatic t_config_seq();
    start_i = 1'b1; step();
    expect_out("R2 start to increment", E_INC);
    step();
    expect_out("R3 increment then offset", E_OFF);
    step();
    expect_out("R4 offset then wait", E_WAIT);
    step(); step();
    expect_out("R2 start held ignored in wait", E_WAIT);
    start_i = 1'b0;
    repeat (4) step();
    expect_out("R5 wait holds", E_WAIT);
  endtask

  task automatic t_trigger();
    trig_i = 1'b1; step();
    expect_out("R6 trigger from wait", E_PRST);
    step();
    expect_out("R6 phase-reset to run", E_RUN);
    repeat (3) step();
    expect_out("R8 held trigger one reset", E_RUN);
    trig_i = 1'b0; step();
    expect_out("R7 run holds", E_RUN);
    trig_i = 1'b1; step(); trig_i = 1'b0;
    expect_out("R7 trigger in run", E_PRST);
    step();
    expect_out("R6 back to run", E_RUN);
    start_i = 1'b1; step(); start_i = 1'b0;
    expect_out("R2 start ignored in run", E_RUN);
  endtask

  task automatic t_stop();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    expect_out("R9 stop from run", E_IDLE);
    start_i = 1'b1; step(); start_i = 1'b0;
    stop_i = 1'b1; step(); stop_i = 1'b0;
    expect_out("R9 stop from increment", E_IDLE);
    start_i = 1'b1; step(); start_i = 1'b0;
    step();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    expect_out("R9 stop from offset", E_IDLE);
    go_to_wait();
    stop_i = 1'b1; trig_i = 1'b1; step(); stop_i = 1'b0; trig_i = 1'b0;
    expect_out("R9 stop beats trigger in wait", E_IDLE);
    go_to_wait();
    trig_i = 1'b1; step(); trig_i = 1'b0;
    stop_i = 1'b1; step(); stop_i = 1'b0;
    expect_out("R9 stop from phase-reset", E_IDLE);
    go_to_wait();
    trig_i = 1'b1; step(); trig_i = 1'b0; step();
    stop_i = 1'b1; trig_i = 1'b1; step(); stop_i = 1'b0; trig_i = 1'b0;
    expect_out("R9 stop beats trigger in run", E_IDLE);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle_ignore();
        t_config_seq();
        t_trigger();
        t_stop();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule